// File: doc/BRIEF.md
# Serial Port Host Register File with Prioritized Interrupt Identification

This block is the processor-facing side of a classic eight-register serial port. A host reaches it through a select line, a three-bit offset and separate read and write strobes. It holds the configuration registers, which are line control, modem control, FIFO control, scratch and the 16-bit baud divisor. It also gathers status from the receiver, the transmitter and the four modem input lines. The baud generator and both shift registers sit outside. The block hands them the divisor and the control fields, pulses a strobe when the host writes a transmit byte, and pulses a strobe when the host takes a receive byte.

Four interrupt sources are collected into one identification code. Each source can be enabled on its own. The code always names only the most urgent source that is both pending and enabled. A source of lower urgency shows up only after the host has serviced every source above it. A receive timeout sits on the same urgency level as received data, and it is shown only while data is actually waiting. A single interrupt line goes to the host when the host has opened the output gate in modem control.

Top module: `uhr_host_regs`

## Requirements
- R1: After reset the reads are: interrupt enable 0x00, line control 0x00, modem control 0x00, scratch 0xFF, divisor low and high 0x00, identification 0x01, and line status 0x60 (with rx_ready and rx_fifo_err low and tx_idle high). irq_out is low.
- R2: The offset map is as follows. Offset 0 reads rx_data and pulses rbr_rd in the read cycle. Offset 0 writes pulse thr_wr with thr_data equal to the written byte. Offset 3 is line control and offset 7 is scratch; both are fully read/write. Offset 4 is modem control, which keeps bits 4:0 and reads bits 7:5 as zero. A write to offset 2 loads fcr_q, and bits 7:6 of the identification read both mirror fcr_q bit 0.
- R3: While line control bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes, and divisor outputs {high,low}. Such writes neither pulse thr_wr nor change the interrupt enable register.
- R4: At offset 1, interrupt enable bits 0..3 gate received data, transmit-holding-empty, line status and modem status in that order. Bits 7:4 always read zero.
- R5: Line status layout is: bit 0 rx_ready, bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bit 5 holding register empty, bit 6 holding empty AND tx_idle, bit 7 rx_fifo_err. Bits 1..4 are sticky from their event pulses and are cleared by a line status read. Bit 5 clears on a transmit write and sets on tx_load. Writes to offset 5 have no effect.
- R6: Modem status bits 7..4 hold modem_lines[3..0] (CD, RI, DSR, CTS) one clock after they change. Bits 3..0 are change flags for the same lines. CD, DSR and CTS flag any change, while RI flags only a 1-to-0 change. Reading offset 6 clears the flags.
- R7: Identification bits 3:0 read 0x6 for line status, 0x4 for received data, 0xC for receive timeout, 0x2 for holding empty, 0x0 for modem status and 0x1 for none. Urgency runs in that order from highest, and only the highest enabled pending source is shown.
- R8: Received data and timeout share one level. While rx_ready is high, a high rx_timeout selects code 0xC instead of 0x4. With rx_ready low, a timeout is not reported.
- R9: The holding-empty interrupt is raised by tx_load, or by interrupt enable bit 1 going from 0 to 1 while the holding register is empty. A transmit write clears it, and so does an identification read that returns its code. An identification read that shows a higher source leaves it pending.
- R10: irq_out is high exactly when modem control bit 3 is set and some enabled source is pending.
- R11: After the shown source is serviced, the next lower pending source becomes the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register file select |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| rx_data | input | 8 | Byte at the head of the receiver |
| rbr_rd | output | 1 | Receive byte taken by host |
| thr_data | output | 8 | Byte written for transmission |
| thr_wr | output | 1 | Transmit byte write strobe |
| rx_ready | input | 1 | Receiver holds data |
| rx_timeout | input | 1 | Receiver character timeout |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_framing | input | 1 | Framing error event pulse |
| ev_break | input | 1 | Break event pulse |
| rx_fifo_err | input | 1 | Receive FIFO holds an errored byte |
| tx_load | input | 1 | Transmitter took the holding byte |
| tx_idle | input | 1 | Transmit shifter empty |
| modem_lines | input | 4 | {CD, RI, DSR, CTS} |
| lcr_q | output | 8 | Line control register |
| mcr_q | output | 5 | Modem control register |
| fcr_q | output | 8 | FIFO control register |
| divisor | output | 16 | Baud divisor |
| irq_out | output | 1 | Interrupt request |

## Verification
Read data and the identification code are combinational from the offset, so the bench samples rdata one nanosecond after it drives a read and before the clock edge that applies any read-clear. The effects of writes, event pulses and read-clears appear after exactly one rising edge. Modem line changes likewise need one edge before the status and flags reflect them, and the bench waits that edge before reading. irq_out follows register state with no extra register, so it is checked in the same cycle the identification is read. A seeded random phase mixes events, line changes and enable values, and it compares every identification read against a bench-side priority model.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
   localparam int unsigned REG_DW = 8;
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_IER  = 3'd1;
   localparam logic [2:0] OFS_IIR  = 3'd2;
   localparam logic [2:0] OFS_LCR  = 3'd3;
   localparam logic [2:0] OFS_MCR  = 3'd4;
   localparam logic [2:0] OFS_LSR  = 3'd5;
   localparam logic [2:0] OFS_MSR  = 3'd6;
   localparam logic [2:0] OFS_SCR  = 3'd7;

   typedef enum logic [2:0] {
      IID_MS   = 3'b000,
      IID_THRE = 3'b001,
      IID_RX   = 3'b010,
      IID_LS   = 3'b011,
      IID_TO   = 3'b110
   } iid_e;
endpackage

// File: rtl/uhr_lsr_track.sv
module uhr_lsr_track #(
   parameter int unsigned NFLAG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] ev,
   input  logic             clr,
   output logic [NFLAG-1:0] flags
);
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (clr ? '0 : flags) | ev;
   end

   // R5: a status read with no coincident event leaves no flag set
   assert_lsr_rdclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ev == '0) |=> (flags == '0));
   // R5: without a read, flags only accumulate
   assert_lsr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/uhr_msr_track.sv
module uhr_msr_track #(
   parameter int unsigned NLINE = 4,
   parameter bit          RI_TRAILING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NLINE-1:0] lines_in,
   input  logic             clr,
   output logic [NLINE-1:0] lines_q,
   output logic [NLINE-1:0] delta
);
   localparam int unsigned RI_BIT = 2;
   logic [NLINE-1:0] chg;

   if (NLINE != 4) begin : g_bad_nline
      $error("uhr_msr_track expects exactly four modem lines");
   end

   if (RI_TRAILING) begin : g_ri_trail
      always_comb begin
         chg = lines_q ^ lines_in;
         chg[RI_BIT] = lines_q[RI_BIT] & ~lines_in[RI_BIT];
      end
   end else begin : g_ri_any
      assign chg = lines_q ^ lines_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lines_q <= '0;
         delta   <= '0;
      end else begin
         lines_q <= lines_in;
         delta   <= (clr ? '0 : delta) | chg;
      end
   end

   // R6: reading with steady lines empties the change flags
   assert_msr_rdclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && lines_in == lines_q) |=> (delta == '0));
endmodule

// File: rtl/uhr_irq_prio.sv
module uhr_irq_prio
   import uhr_pkg::*;
(
   input  logic [3:0] ier,
   input  logic       ls_any,
   input  logic       rx_ready,
   input  logic       rx_timeout,
   input  logic       thre_pend,
   input  logic       ms_any,
   output logic       pend,
   output iid_e       iid
);
   always_comb begin
      pend = 1'b1;
      iid  = IID_MS;
      if (ier[2] && ls_any)          iid = IID_LS;
      else if (ier[0] && rx_ready)   iid = rx_timeout ? IID_TO : IID_RX;
      else if (ier[1] && thre_pend)  iid = IID_THRE;
      else if (ier[3] && ms_any)     iid = IID_MS;
      else                           pend = 1'b0;
   end
endmodule

// File: rtl/uhr_host_regs.sv
module uhr_host_regs
   import uhr_pkg::*;
#(
   parameter logic [7:0]  SCR_INIT       = 8'hFF,
   parameter int unsigned MCR_W          = 5,
   parameter bit          RI_TRAILING    = 1'b1,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic [2:0]       addr,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic [7:0]       rx_data,
   output logic             rbr_rd,
   output logic [7:0]       thr_data,
   output logic             thr_wr,
   input  logic             rx_ready,
   input  logic             rx_timeout,
   input  logic             ev_overrun,
   input  logic             ev_parity,
   input  logic             ev_framing,
   input  logic             ev_break,
   input  logic             rx_fifo_err,
   input  logic             tx_load,
   input  logic             tx_idle,
   input  logic [3:0]       modem_lines,
   output logic [7:0]       lcr_q,
   output logic [MCR_W-1:0] mcr_q,
   output logic [7:0]       fcr_q,
   output logic [15:0]      divisor,
   output logic             irq_out
);
   localparam int unsigned NLS      = 4;
   localparam int unsigned NMS      = 4;
   localparam int unsigned DLAB_BIT = REG_DW - 1;
   localparam int unsigned IRQ_GATE = 3;

   if (MCR_W < IRQ_GATE + 1 || MCR_W > REG_DW) begin : g_bad_mcr
      $error("MCR_W must cover the interrupt gate bit and fit one byte");
   end

   logic [3:0]       ier;
   logic [7:0]       dll, dlm, scr;
   logic             thr_empty, thre_pend;
   logic [NLS-1:0]   ls_flags;
   logic [NMS-1:0]   ms_lines, ms_delta;
   logic             pend;
   iid_e             iid;

   wire dlab   = lcr_q[DLAB_BIT];
   wire wr_hit = sel & wr_en;
   wire rd_hit = sel & rd_en;
   wire ier_wr = wr_hit && addr == OFS_IER && !dlab;
   wire lsr_rd = rd_hit && addr == OFS_LSR;
   wire msr_rd = rd_hit && addr == OFS_MSR;
   wire iir_rd = rd_hit && addr == OFS_IIR;

   assign thr_wr   = wr_hit && addr == OFS_DATA && !dlab;
   assign rbr_rd   = rd_hit && addr == OFS_DATA && !dlab;
   assign thr_data = wdata;
   assign divisor  = {dlm, dll};

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ier   <= '0;
         lcr_q <= '0;
         mcr_q <= '0;
         fcr_q <= '0;
         scr   <= SCR_INIT;
         dll   <= '0;
         dlm   <= '0;
      end else if (wr_hit) begin
         case (addr)
            OFS_DATA: if (dlab) dll <= wdata;
            OFS_IER:  if (dlab) dlm <= wdata; else ier <= wdata[3:0];
            OFS_IIR:  fcr_q <= wdata;
            OFS_LCR:  lcr_q <= wdata;
            OFS_MCR:  mcr_q <= wdata[MCR_W-1:0];
            OFS_SCR:  scr   <= wdata;
            default:  ;
         endcase
      end
   end

   // holding register state and its interrupt
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_empty <= 1'b1;
         thre_pend <= 1'b0;
      end else begin
         if (thr_wr)       thr_empty <= 1'b0;
         else if (tx_load) thr_empty <= 1'b1;

         if (thr_wr)
            thre_pend <= 1'b0;
         else if (tx_load || (ier_wr && wdata[1] && !ier[1] && thr_empty))
            thre_pend <= 1'b1;
         else if (iir_rd && pend && iid == IID_THRE)
            thre_pend <= 1'b0;
      end
   end

   uhr_lsr_track #(.NFLAG(NLS)) u_lsr (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    ({ev_break, ev_framing, ev_parity, ev_overrun}),
      .clr   (lsr_rd),
      .flags (ls_flags)
   );

   uhr_msr_track #(.NLINE(NMS), .RI_TRAILING(RI_TRAILING)) u_msr (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_in (modem_lines),
      .clr      (msr_rd),
      .lines_q  (ms_lines),
      .delta    (ms_delta)
   );

   uhr_irq_prio u_prio (
      .ier        (ier),
      .ls_any     (|ls_flags),
      .rx_ready   (rx_ready),
      .rx_timeout (rx_timeout),
      .thre_pend  (thre_pend),
      .ms_any     (|ms_delta),
      .pend       (pend),
      .iid        (iid)
   );

   // read multiplexer
   always_comb begin
      case (addr)
         OFS_DATA: rdata = dlab ? dll : rx_data;
         OFS_IER:  rdata = dlab ? dlm : {4'b0000, ier};
         OFS_IIR:  rdata = {fcr_q[0], fcr_q[0], 2'b00, iid, ~pend};
         OFS_LCR:  rdata = lcr_q;
         OFS_MCR:  rdata = 8'(mcr_q);
         OFS_LSR:  rdata = {rx_fifo_err, thr_empty & tx_idle, thr_empty,
                            ls_flags, rx_ready};
         OFS_MSR:  rdata = {ms_lines, ms_delta};
         default:  rdata = scr;
      endcase
   end

   if (IRQ_REGISTERED) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= mcr_q[IRQ_GATE] & pend;
      end
      assign irq_out = irq_q;
   end else begin : g_irq_comb
      assign irq_out = mcr_q[IRQ_GATE] & pend;
      // R10: a raised line always has an enabled source behind it
      assert_irq_has_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out |-> (ier != 4'b0000));
   end

   // R9: a transmit write always leaves the holding-empty interrupt cleared
   assert_thre_wrclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !thre_pend);
   // R3: divisor-mode writes at offset 1 never alter the enables
   assert_dlab_ier_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && addr == OFS_IER && dlab) |=> $stable(ier));
   // R2: a transmit strobe implies a receive strobe is absent
   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |-> !rbr_rd);
endmodule

// File: tb/tb_uhr_host_regs.sv
module tb_uhr_host_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 0, wr_en = 0, rd_en = 0;
   logic [2:0] addr = 0;
   logic [7:0] wdata = 0, rx_data = 8'h5A;
   logic       rx_ready = 0, rx_timeout = 0;
   logic       ev_overrun = 0, ev_parity = 0, ev_framing = 0, ev_break = 0;
   logic       rx_fifo_err = 0, tx_load = 0, tx_idle = 1;
   logic [3:0] modem_lines = 0;
   wire  [7:0] rdata, thr_data, lcr_q, fcr_q;
   wire  [4:0] mcr_q;
   wire [15:0] divisor;
   wire        rbr_rd, thr_wr, irq_out;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uhr_host_regs dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_en(wr_en),
      .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rx_data(rx_data),
      .rbr_rd(rbr_rd), .thr_data(thr_data), .thr_wr(thr_wr),
      .rx_ready(rx_ready), .rx_timeout(rx_timeout), .ev_overrun(ev_overrun),
      .ev_parity(ev_parity), .ev_framing(ev_framing), .ev_break(ev_break),
      .rx_fifo_err(rx_fifo_err), .tx_load(tx_load), .tx_idle(tx_idle),
      .modem_lines(modem_lines), .lcr_q(lcr_q), .mcr_q(mcr_q), .fcr_q(fcr_q),
      .divisor(divisor), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      sel = 1; wr_en = 1; addr = a; wdata = d;
      tick();
      sel = 0; wr_en = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      sel = 1; rd_en = 1; addr = a; #1;
      d = rdata;
      tick();
      sel = 0; rd_en = 0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   // e[0] overrun, e[1] parity, e[2] framing, e[3] break
   task automatic pulse_ev(input logic [3:0] e);
      {ev_break, ev_framing, ev_parity, ev_overrun} = e;
      tick();
      {ev_break, ev_framing, ev_parity, ev_overrun} = 4'b0;
   endtask

   task automatic set_lines(input logic [3:0] l);
      modem_lines = l;
      tick();
   endtask

   // expected identification nibble from the priority rules (R7, R8)
   function automatic logic [3:0] exp_iid(input logic [3:0] ie, input logic [3:0] ls,
      input logic rr, input logic to, input logic th, input logic [3:0] ms);
      if (ie[2] && ls != 0)  return 4'h6;
      if (ie[0] && rr)       return to ? 4'hC : 4'h4;
      if (ie[1] && th)       return 4'h2;
      if (ie[3] && ms != 0)  return 4'h0;
      return 4'h1;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [3:0] m_ier, m_ls, m_delta, cur_lines, nl, e, exp;
      logic       m_thre;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset values
      chk("R1 irq", irq_out, 0);
      rd_chk("R1 IER", 3'd1, 8'h00);
      rd_chk("R1 IIR", 3'd2, 8'h01);
      rd_chk("R1 LCR", 3'd3, 8'h00);
      rd_chk("R1 MCR", 3'd4, 8'h00);
      rd_chk("R1 LSR", 3'd5, 8'h60);
      rd_chk("R1 MSR", 3'd6, 8'h00);
      rd_chk("R1 SCR", 3'd7, 8'hFF);

      // R2 offset map
      wr(3'd7, 8'hA5); rd_chk("R2 SCR", 3'd7, 8'hA5);
      wr(3'd3, 8'h03); rd_chk("R2 LCR", 3'd3, 8'h03);
      chk("R2 lcr_q", lcr_q, 8'h03);
      wr(3'd4, 8'hFF); rd_chk("R2 MCR upper zero", 3'd4, 8'h1F);
      sel = 1; wr_en = 1; addr = 3'd0; wdata = 8'h3C; #1;
      chk("R2 thr_wr", thr_wr, 1);
      chk("R2 thr_data", thr_data, 8'h3C);
      tick(); sel = 0; wr_en = 0;
      rd_chk("R5 LSR after THR write", 3'd5, 8'h00);
      tx_load = 1; tick(); tx_load = 0;
      rd_chk("R5 LSR after tx_load", 3'd5, 8'h60);
      sel = 1; rd_en = 1; addr = 3'd0; #1;
      chk("R2 RBR data", rdata, 8'h5A);
      chk("R2 rbr_rd", rbr_rd, 1);
      tick(); sel = 0; rd_en = 0;
      wr(3'd2, 8'hC1);
      chk("R2 fcr_q", fcr_q, 8'hC1);

      // R4 enable register upper bits
      wr(3'd1, 8'hF0); rd_chk("R4 IER upper zero", 3'd1, 8'h00);
      wr(3'd1, 8'h05);

      // R3 divisor access
      wr(3'd3, 8'h83);
      rd_chk("R1 DLL reset", 3'd0, 8'h00);
      rd_chk("R1 DLM reset", 3'd1, 8'h00);
      sel = 1; wr_en = 1; addr = 3'd0; wdata = 8'h34; #1;
      chk("R3 no thr_wr in divisor mode", thr_wr, 0);
      tick(); sel = 0; wr_en = 0;
      wr(3'd1, 8'h12);
      chk("R3 divisor", divisor, 16'h1234);
      rd_chk("R3 DLL", 3'd0, 8'h34);
      rd_chk("R3 DLM", 3'd1, 8'h12);
      wr(3'd3, 8'h03);
      rd_chk("R3 IER untouched", 3'd1, 8'h05);
      wr(3'd1, 8'h00);

      // R9 holding empty interrupt (pending from earlier tx_load)
      wr(3'd1, 8'h02);
      chk("R10 irq with THRE", irq_out, 1);
      rd_chk("R9 IIR THRE", 3'd2, 8'hC2);
      rd_chk("R9 IIR cleared by read", 3'd2, 8'hC1);
      chk("R10 irq low", irq_out, 0);
      wr(3'd1, 8'h00); wr(3'd1, 8'h02);
      wr(3'd0, 8'h77);
      rd_chk("R9 cleared by THR write", 3'd2, 8'hC1);
      tx_load = 1; tick(); tx_load = 0;
      rd_chk("R9 raised by tx_load", 3'd2, 8'hC2);

      // R7 R8 R11 priority walk
      wr(3'd1, 8'h00); wr(3'd1, 8'h0F);
      rx_ready = 1;
      pulse_ev(4'b0010);
      set_lines(4'b0001);
      rd_chk("R7 LS highest", 3'd2, 8'hC6);
      rd_chk("R7 LS read keeps", 3'd2, 8'hC6);
      rd_chk("R5 LSR parity+ready", 3'd5, 8'h65);
      rd_chk("R11 RX after LS", 3'd2, 8'hC4);
      rx_timeout = 1; #1;
      rd_chk("R8 timeout same level", 3'd2, 8'hCC);
      rx_ready = 0; #1;
      rd_chk("R8 no timeout when empty", 3'd2, 8'hC2);
      rd_chk("R11 MS after THRE", 3'd2, 8'hC0);
      rx_timeout = 0;
      rd_chk("R6 MSR CTS", 3'd6, 8'h11);
      rd_chk("R7 none", 3'd2, 8'hC1);

      // R6 modem status deltas
      set_lines(4'b0101);
      rd_chk("R6 RI rise no delta", 3'd6, 8'h50);
      set_lines(4'b0001);
      rd_chk("R6 RI fall delta", 3'd6, 8'h14);
      set_lines(4'b1001);
      rd_chk("R6 CD delta", 3'd6, 8'h98);
      rd_chk("R6 cleared", 3'd6, 8'h90);

      // R10 output gate
      wr(3'd4, 8'h00);
      pulse_ev(4'b0100);
      chk("R10 gated off", irq_out, 0);
      rd_chk("R10 IIR LS", 3'd2, 8'hC6);
      wr(3'd4, 8'h08);
      chk("R10 gated on", irq_out, 1);
      rd_chk("R5 framing", 3'd5, 8'h68);
      chk("R10 after service", irq_out, 0);

      // R5 remaining fields
      pulse_ev(4'b1001);
      rd_chk("R5 break+overrun", 3'd5, 8'h72);
      rd_chk("R5 read clears", 3'd5, 8'h60);
      wr(3'd5, 8'hFF);
      rd_chk("R5 write ignored", 3'd5, 8'h60);
      rx_fifo_err = 1; #1;
      rd_chk("R5 fifo error", 3'd5, 8'hE0);
      rx_fifo_err = 0;

      // random phase against the priority model (R7 R8 R9 R10 R11)
      wr(3'd1, 8'h00);
      m_ier = 0; m_ls = 0; m_delta = 0; m_thre = 0; cur_lines = 4'b1001;
      for (int i = 0; i < 60; i++) begin
         e = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0;
         if (e != 0) begin pulse_ev(e); m_ls |= e; end
         if ($urandom % 2 == 1) begin
            nl = 4'($urandom);
            m_delta[3] |= nl[3] ^ cur_lines[3];
            m_delta[2] |= cur_lines[2] & ~nl[2];
            m_delta[1] |= nl[1] ^ cur_lines[1];
            m_delta[0] |= nl[0] ^ cur_lines[0];
            cur_lines = nl;
            set_lines(nl);
         end
         rx_ready = 1'($urandom); rx_timeout = 1'($urandom);
         v = 8'($urandom);
         if (!m_ier[1] && v[1]) m_thre = 1;
         wr(3'd1, v); m_ier = v[3:0];
         exp = exp_iid(m_ier, m_ls, rx_ready, rx_timeout, m_thre, m_delta);
         chk("R10 random irq", irq_out, (exp == 4'h1) ? 0 : 1);
         rd(3'd2, v);
         chk("R7 random IIR", v[3:0], exp);
         if (exp == 4'h2) m_thre = 0;
         if ($urandom % 2 == 1) begin
            rd_chk("R5 random LSR", 3'd5, {3'b011, m_ls, rx_ready});
            m_ls = 0;
         end
         if ($urandom % 2 == 1) begin
            rd_chk("R6 random MSR", 3'd6, {cur_lines, m_delta});
            m_delta = 0;
         end
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule